// File: doc/BRIEF.md
# Fast Link Pulse Page Receiver

This block turns the pulse trains of a link-partner negotiation burst into 16-bit pages. It watches a synchronized, single-cycle pulse-detect strobe and times the distance between successive pulses against two tolerance windows. The two windows sit around one and around two nominal slot spacings, and both are set in clock cycles. Every burst carries clock pulses in its odd slots, 33 slots in all. A pulse about one slot after a clock pulse is a data pulse and stands for a 1. A clock pulse that comes about two slots after the previous clock pulse, with no pulse between them, marks a 0.

A burst closes when the line has been silent for a set timeout. If exactly seventeen clock pulses were seen, the page is presented with a one-cycle valid strobe. A burst with a gap that fits neither window, with too few clock pulses, or with a pulse after the seventeenth clock pulse is discarded and flagged instead. A burst flagged on a pulse ignores its remaining pulses until the line falls silent. A match flag rises once the same page has arrived at least three times in a row. The upper layer uses that flag to know that a partner's base page is settled and can be acted on.

Top module: `flp_page_rx`

## Requirements
- R1: While reset is applied and in the first cycle after it, page_valid_o, burst_err_o and match_o are 0 and page_o is 0.
- R2: Bit n of page_o (bit 0 first) is 1 when a data pulse preceded the (n+2)-th clock pulse of the burst, and 0 when it did not.
- R3: A gap between SLOT_CLKS-TOL_CLKS and SLOT_CLKS+TOL_CLKS cycles (inclusive) is a data-length gap, and a gap between 2*SLOT_CLKS-TOL_CLKS and 2*SLOT_CLKS+TOL_CLKS cycles is a clock-length gap. Both window edges are accepted, and one cycle beyond either edge is not.
- R4: A pulse whose gap fits neither window, or fits the wrong one for the current position, raises burst_err_o for one cycle. No page is delivered for that burst, and later pulses are ignored until TIMEOUT_CLKS cycles of silence.
- R5: A burst that falls silent with fewer than 17 clock pulses raises burst_err_o and delivers no page.
- R6: Any pulse after the 17th clock pulse of a burst, before the silence timeout, raises burst_err_o and delivers no page.
- R7: page_valid_o is high for exactly one cycle, due TIMEOUT_CLKS cycles after the edge that sampled the burst's last pulse. page_o changes only together with page_valid_o and holds between deliveries.
- R8: match_o is high from the cycle after the third consecutive identical page is delivered, and it stays high while further identical pages arrive.
- R9: A delivered page that differs from the previous one restarts the identical-page count at one, so match_o drops.
- R10: A flagged burst clears the identical-page count and drops match_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Synchronized single-cycle pulse-detect strobe |
| page_o | output | PAGE_W | Last delivered page, bit 0 received first |
| page_valid_o | output | 1 | One-cycle strobe for a newly delivered page |
| burst_err_o | output | 1 | One-cycle strobe for a malformed burst |
| match_o | output | 1 | Same page delivered at least MATCH_N times in a row |

## Verification
A page and its valid strobe are due exactly TIMEOUT_CLKS cycles after the edge that samples the last pulse of the burst. match_o follows one cycle later. An error caused by a bad gap or a surplus pulse shows in the cycle after the offending pulse is sampled, and an error for a short burst shows when the timeout expires. The bench drives pulses at falling edges and tallies strobes with a falling-edge monitor. It reads the tallies and match_o TIMEOUT_CLKS+2 cycles after each burst. One directed probe checks the valid strobe and the match rise at their exact cycles.

// File: rtl/flp_rx_pkg.sv
package flp_rx_pkg;

    typedef enum logic [1:0] {
        GAP_BAD   = 2'd0,
        GAP_DATA  = 2'd1,
        GAP_CLOCK = 2'd2
    } gap_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_DRAIN = 2'd2
    } dec_state_e;

endpackage

// File: rtl/flp_gap_timer.sv
module flp_gap_timer
    import flp_rx_pkg::*;
#(
    parameter int SLOT_CLKS    = 16,
    parameter int TOL_CLKS     = 3,
    parameter int TIMEOUT_CLKS = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pulse_i,
    output gap_cls_e gap_cls_o,
    output logic     silence_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CLKS + 1);
    localparam logic [CNT_W:0] DATA_LO = (CNT_W+1)'(SLOT_CLKS - TOL_CLKS);
    localparam logic [CNT_W:0] DATA_HI = (CNT_W+1)'(SLOT_CLKS + TOL_CLKS);
    localparam logic [CNT_W:0] CLK_LO  = (CNT_W+1)'(2*SLOT_CLKS - TOL_CLKS);
    localparam logic [CNT_W:0] CLK_HI  = (CNT_W+1)'(2*SLOT_CLKS + TOL_CLKS);
    localparam logic [CNT_W:0] TMO     = (CNT_W+1)'(TIMEOUT_CLKS);
    localparam logic [CNT_W-1:0] SAT   = CNT_W'(TIMEOUT_CLKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W:0] gap;

    // gap = cycles between the previous sampled pulse and this edge
    always_comb begin
        tmr_d = tmr_q;
        gap   = {1'b0, tmr_q.cnt} + 1'b1;
        if (pulse_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != SAT) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end

        if (gap >= DATA_LO && gap <= DATA_HI) begin
            gap_cls_o = GAP_DATA;
        end else if (gap >= CLK_LO && gap <= CLK_HI) begin
            gap_cls_o = GAP_CLOCK;
        end else begin
            gap_cls_o = GAP_BAD;
        end
        silence_o = !pulse_i && (gap >= TMO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= SAT;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/flp_burst_decoder.sv
module flp_burst_decoder
    import flp_rx_pkg::*;
#(
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    input  gap_cls_e          gap_cls_i,
    input  logic              silence_i,
    output logic [PAGE_W-1:0] page_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int CLK_TOTAL = PAGE_W + 1;
    localparam int NCLK_W    = $clog2(CLK_TOTAL + 1);
    localparam logic [NCLK_W-1:0] LAST_CLK = NCLK_W'(CLK_TOTAL);

    typedef struct packed {
        dec_state_e        st;
        logic              data_seen;
        logic [NCLK_W-1:0] nclk;
        logic [PAGE_W-1:0] shreg;
        logic [PAGE_W-1:0] page;
        logic              valid;
        logic              err;
    } dec_t;

    dec_t dec_d, dec_q;
    logic bit_close;

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = 1'b0;
        dec_d.err   = 1'b0;
        // a clock pulse closes a bit: after a data pulse at data spacing,
        // or straight after a clock pulse at clock spacing
        bit_close = (gap_cls_i == GAP_DATA  &&  dec_q.data_seen) ||
                    (gap_cls_i == GAP_CLOCK && !dec_q.data_seen);
        unique case (dec_q.st)
            ST_IDLE: begin
                if (pulse_i) begin
                    dec_d.st        = ST_RECV;
                    dec_d.nclk      = NCLK_W'(1);
                    dec_d.data_seen = 1'b0;
                    dec_d.shreg     = '0;
                end
            end
            ST_RECV: begin
                if (pulse_i) begin
                    if (dec_q.nclk == LAST_CLK) begin
                        dec_d.err = 1'b1;
                        dec_d.st  = ST_DRAIN;
                    end else if (gap_cls_i == GAP_DATA && !dec_q.data_seen) begin
                        dec_d.data_seen = 1'b1;
                    end else if (bit_close) begin
                        dec_d.shreg     = {dec_q.data_seen, dec_q.shreg[PAGE_W-1:1]};
                        dec_d.nclk      = dec_q.nclk + 1'b1;
                        dec_d.data_seen = 1'b0;
                    end else begin
                        dec_d.err = 1'b1;
                        dec_d.st  = ST_DRAIN;
                    end
                end else if (silence_i) begin
                    dec_d.st = ST_IDLE;
                    if (dec_q.nclk == LAST_CLK) begin
                        dec_d.valid = 1'b1;
                        dec_d.page  = dec_q.shreg;
                    end else begin
                        dec_d.err = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (silence_i) begin
                    dec_d.st = ST_IDLE;
                end
            end
            default: dec_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q.st        <= ST_IDLE;
            dec_q.data_seen <= 1'b0;
            dec_q.nclk      <= '0;
            dec_q.shreg     <= '0;
            dec_q.page      <= '0;
            dec_q.valid     <= 1'b0;
            dec_q.err       <= 1'b0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign page_o  = dec_q.page;
    assign valid_o = dec_q.valid;
    assign err_o   = dec_q.err;

endmodule

// File: rtl/flp_page_matcher.sv
module flp_page_matcher #(
    parameter int PAGE_W  = 16,
    parameter int MATCH_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              valid_i,
    input  logic              err_i,
    output logic              match_o
);
    localparam int RUN_W = $clog2(MATCH_N + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MATCH_N);

    typedef struct packed {
        logic [PAGE_W-1:0] prev;
        logic [RUN_W-1:0]  run;
        logic              match;
    } mat_t;

    mat_t mat_d, mat_q;

    always_comb begin
        mat_d = mat_q;
        if (err_i) begin
            mat_d.run = '0;
        end else if (valid_i) begin
            mat_d.prev = page_i;
            if (mat_q.run != '0 && page_i == mat_q.prev) begin
                if (mat_q.run != RUN_MAX) begin
                    mat_d.run = mat_q.run + 1'b1;
                end
            end else begin
                mat_d.run = RUN_W'(1);
            end
        end
        mat_d.match = (mat_d.run == RUN_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mat_q.prev  <= '0;
            mat_q.run   <= '0;
            mat_q.match <= 1'b0;
        end else begin
            mat_q <= mat_d;
        end
    end

    assign match_o = mat_q.match;

endmodule

// File: rtl/flp_page_rx.sv
module flp_page_rx
    import flp_rx_pkg::*;
#(
    parameter int PAGE_W       = 16,
    parameter int SLOT_CLKS    = 16,
    parameter int TOL_CLKS     = 3,
    parameter int TIMEOUT_CLKS = 64,
    parameter int MATCH_N      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    output logic [PAGE_W-1:0] page_o,
    output logic              page_valid_o,
    output logic              burst_err_o,
    output logic              match_o
);
    gap_cls_e gap_cls;
    logic     silence;
    logic     dec_valid;
    logic     dec_err;

    flp_gap_timer #(
        .SLOT_CLKS   (SLOT_CLKS),
        .TOL_CLKS    (TOL_CLKS),
        .TIMEOUT_CLKS(TIMEOUT_CLKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_i  (pulse_i),
        .gap_cls_o(gap_cls),
        .silence_o(silence)
    );

    flp_burst_decoder #(
        .PAGE_W(PAGE_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_i  (pulse_i),
        .gap_cls_i(gap_cls),
        .silence_i(silence),
        .page_o   (page_o),
        .valid_o  (dec_valid),
        .err_o    (dec_err)
    );

    flp_page_matcher #(
        .PAGE_W (PAGE_W),
        .MATCH_N(MATCH_N)
    ) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .page_i (page_o),
        .valid_i(dec_valid),
        .err_i  (dec_err),
        .match_o(match_o)
    );

    assign page_valid_o = dec_valid;
    assign burst_err_o  = dec_err;

endmodule

// File: rtl/flp_page_rx_chk.sv
module flp_page_rx_chk #(
    parameter int PAGE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PAGE_W-1:0] page_o,
    input logic              page_valid_o,
    input logic              burst_err_o,
    input logic              match_o
);
    assert_valid_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(page_valid_o && burst_err_o));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        page_valid_o |=> !page_valid_o);

    assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !page_valid_o |-> $stable(page_o));

    assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_err_o |=> !burst_err_o);

    assert_match_after_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> $past(page_valid_o));

    assert_err_drops_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_err_o |=> !match_o);

endmodule

bind flp_page_rx flp_page_rx_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .page_o      (page_o),
    .page_valid_o(page_valid_o),
    .burst_err_o (burst_err_o),
    .match_o     (match_o)
);

// File: tb/flp_page_rx_test.sv
`timescale 1ns/1ps
module flp_page_rx_test;
    localparam int PW   = 16;
    localparam int SLOT = 16;
    localparam int TOL  = 3;
    localparam int TMO  = 64;
    localparam int NV   = 9;

    // {page, clock gap, data gap, expected match_o}
    localparam logic [39:0] VEC [NV] = '{
        {16'hA5C3, 8'd32, 8'd16, 8'd0},
        {16'hA5C3, 8'd29, 8'd13, 8'd0},
        {16'hA5C3, 8'd35, 8'd19, 8'd1},
        {16'hA5C3, 8'd31, 8'd17, 8'd1},
        {16'h0001, 8'd32, 8'd16, 8'd0},
        {16'h0001, 8'd33, 8'd15, 8'd0},
        {16'h0001, 8'd32, 8'd16, 8'd1},
        {16'h0000, 8'd32, 8'd16, 8'd0},
        {16'hFFFF, 8'd32, 8'd16, 8'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pulse_i = 1'b0;
    logic [PW-1:0] page_o;
    logic          page_valid_o;
    logic          burst_err_o;
    logic          match_o;

    int checks = 0;
    int errors = 0;
    int nvalid = 0;
    int nerr   = 0;
    logic [PW-1:0] last_page = '0;

    flp_page_rx #(.PAGE_W(PW), .SLOT_CLKS(SLOT), .TOL_CLKS(TOL),
                  .TIMEOUT_CLKS(TMO), .MATCH_N(3)) uut (
        .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .page_o(page_o),
        .page_valid_o(page_valid_o), .burst_err_o(burst_err_o), .match_o(match_o)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (page_valid_o) begin
                nvalid++;
                last_page = page_o;
            end
            if (burst_err_o) nerr++;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // pulse sampled gap cycles after the previous sampled pulse
    task automatic pulse_after(int gap);
        repeat (gap - 1) @(negedge clk);
        pulse_i = 1'b1;
        @(negedge clk);
        pulse_i = 1'b0;
    endtask

    task automatic send_bits(logic [PW-1:0] pg, int nbits, int cg, int dg);
        pulse_after(1);
        for (int i = 0; i < nbits; i++) begin
            if (pg[i]) begin
                pulse_after(dg);
                pulse_after(dg);
            end else begin
                pulse_after(cg);
            end
        end
    endtask

    task automatic settle();
        repeat (TMO + 2) @(negedge clk);
        #1;
    endtask

    initial begin
        int v0, e0;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", page_valid_o, 0);
        check("R1 err in reset", burst_err_o, 0);
        check("R1 match in reset", match_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 page after reset", page_o, 0);
        check("R1 match after reset", match_o, 0);

        // vector walk: R2 decoding, R3 window edges, R8/R9 match run
        for (int k = 0; k < NV; k++) begin
            v0 = nvalid; e0 = nerr;
            send_bits(VEC[k][39:24], PW, int'(VEC[k][23:16]), int'(VEC[k][15:8]));
            settle();
            check($sformatf("R2/R3 vec%0d page count", k), nvalid, v0 + 1);
            check($sformatf("R2 vec%0d page value", k), last_page, VEC[k][39:24]);
            check($sformatf("R3 vec%0d no error", k), nerr, e0);
            check($sformatf("R8/R9 vec%0d match", k), match_o, VEC[k][7:0]);
        end

        // R4 bad gap mid-burst, remaining pulses ignored until silence
        v0 = nvalid; e0 = nerr;
        pulse_after(1); pulse_after(32); pulse_after(24);
        for (int i = 0; i < 6; i++) pulse_after(32);
        settle();
        check("R4 one error for bad gap", nerr, e0 + 1);
        check("R4 no page for bad gap", nvalid, v0);
        check("R10 match cleared by error", match_o, 0);

        // R3 gap one below data window and one above clock window
        e0 = nerr; v0 = nvalid;
        pulse_after(1); pulse_after(12);
        settle();
        pulse_after(1); pulse_after(36);
        settle();
        check("R3 out-of-window gaps flagged", nerr, e0 + 2);
        check("R3 out-of-window no page", nvalid, v0);

        // R5 short burst
        e0 = nerr; v0 = nvalid;
        send_bits(16'h00FF, 8, 32, 16);
        settle();
        check("R5 short burst error", nerr, e0 + 1);
        check("R5 short burst no page", nvalid, v0);

        // R6 extra pulse after 17th clock pulse
        e0 = nerr; v0 = nvalid;
        send_bits(16'h1234, PW, 32, 16);
        pulse_after(32);
        settle();
        check("R6 surplus pulse error", nerr, e0 + 1);
        check("R6 surplus pulse no page", nvalid, v0);

        // R10 error breaks a run of identical pages
        send_bits(16'h5A5A, PW, 32, 16); settle();
        send_bits(16'h5A5A, PW, 32, 16); settle();
        pulse_after(1); pulse_after(20); settle();
        send_bits(16'h5A5A, PW, 32, 16); settle();
        check("R10 run restarted after error", match_o, 0);
        send_bits(16'h5A5A, PW, 32, 16); settle();
        check("R10 second after error", match_o, 0);

        // R7/R8 exact timing on the third identical page
        send_bits(16'h5A5A, PW, 32, 16);
        repeat (TMO - 1) @(negedge clk);
        check("R7 valid not early", page_valid_o, 0);
        @(negedge clk);
        check("R7 valid due", page_valid_o, 1);
        check("R7 page with valid", page_o, 16'h5A5A);
        check("R8 match not yet", match_o, 0);
        @(negedge clk);
        check("R7 valid single cycle", page_valid_o, 0);
        check("R8 match rises", match_o, 1);
        check("R7 page held", page_o, 16'h5A5A);
        settle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule